// File: doc/BRIEF.md
# ISA DMA Burst Request Generator

This block drives the DMA request line of an 8-bit ISA disk adapter in bursts that software paces. The host CPU writes to a dedicated I/O trigger port. That write raises the request. The block then counts the byte cycles the host DMA controller acknowledges, and it withdraws the request once a fixed burst of 16 transfers has run. This lets the host take the bus back in time for memory refresh. Software starts each burst with one further port write, so a sector moves as a series of short bursts. The request from the storage device itself is never used.

A refresh gap comes about every 72 bus clocks, and a byte costs roughly 4 clocks. The burst therefore has to stay below 18 bytes, and 16 leaves some margin. The request line has no pull-up. While DMA mode is enabled the block drives it at both levels, through a separate output-enable, and while DMA mode is disabled it releases the line. During every acknowledged cycle the block also asserts a data-register select toward the storage side. All inputs are decoded strobes, active high, and synchronous to the block clock.

Top module: `isa_dma_burst`

## Requirements
- R1: When DMA mode is enabled and no burst is running, a trigger write raises `drq` on the next clock. A trigger write is `iow` high with `trigSel` high and `aen` low.
- R2: An acknowledged DMA cycle is `dack` and `aen` both high together with `ior` (device to memory) or `iow` (memory to device). Either direction counts as one transfer, and the count advances when the strobe ends.
- R3: `drq` falls on the clock after the 16th acknowledged cycle of a burst begins, so no 17th cycle is requested. Acknowledged cycles after that have no effect on `drq`.
- R4: A trigger write made while a burst is running, or while the burst is still finishing, is ignored. It neither restarts nor extends the count.
- R5: A strobe that lacks `dack` or lacks `aen` is not counted, and `devSel` stays low during it.
- R6: `devSel` is high for exactly the duration of each acknowledged DMA cycle while DMA mode is enabled.
- R7: `drqOe` follows `dmaEnable` one clock later. While DMA mode is disabled, `drq` is low and trigger writes are ignored.
- R8: A synchronous reset (`rst` high) clears `drq` and `drqOe` and also clears the transfer count. The next burst then runs a full 16 transfers.
- R9: Once a burst has completed, a new trigger write starts a fresh burst of 16 transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| dmaEnable | input | 1 | DMA mode enable |
| ior | input | 1 | Decoded I/O read strobe, active high |
| iow | input | 1 | Decoded I/O write strobe, active high |
| dack | input | 1 | DMA acknowledge for this channel, active high |
| aen | input | 1 | Address enable (a DMA cycle is in progress) |
| trigSel | input | 1 | Address match for the trigger port |
| drq | output | 1 | DMA request level |
| drqOe | output | 1 | Output-enable for the request driver |
| devSel | output | 1 | Data-register select toward the storage side |

## Verification
The hardest situation to reach is a trigger write that lands in the middle of a running burst. Only a count that carries on undisturbed shows that the write was ignored, and that can be seen only at the 16th cycle afterwards. The stimulus fires a trigger write after five transfers and mixes in strobes that lack `dack` or `aen`. It then checks that `drq` still falls at the start of the 16th acknowledged cycle and not later. A reset in mid-burst, followed by a full burst, shows that the count really was cleared.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;

  // Control toward the datapath
  typedef struct packed {
    logic cntClear;
    logic cntEnable;
  } ctl_strobes_t;

  // Events from the datapath toward the control
  typedef struct packed {
    logic trigEdge;
    logic cycLead;
    logic cycTrail;
    logic cycActive;
    logic lastPending;
  } dp_events_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_TAIL  = 2'd2
  } burst_state_e;

endpackage

// File: rtl/dma_burst_dp.sv
module dma_burst_dp
  import dma_burst_pkg::*;
#(
  parameter int BURST_LEN = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ior,
  input  logic         iow,
  input  logic         dack,
  input  logic         aen,
  input  logic         trigSel,
  input  ctl_strobes_t ctl,
  output dp_events_t   ev
);

  localparam int CNT_W = $clog2(BURST_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BURST_LEN - 1);

  logic             cycNow;
  logic             cycPrev;
  logic             trigNow;
  logic             trigPrev;
  logic [CNT_W-1:0] xferCount;

  // A qualified DMA byte cycle: acknowledged, DMA address phase, either direction
  assign cycNow  = dack & aen & (ior | iow);
  // A CPU write to the trigger port (never during a DMA address phase)
  assign trigNow = iow & trigSel & ~aen;

  always_ff @(posedge clk) begin
    if (rst) begin
      cycPrev  <= 1'b0;
      trigPrev <= 1'b0;
    end else begin
      cycPrev  <= cycNow;
      trigPrev <= trigNow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.cntClear) begin
      xferCount <= '0;
    end else if (ctl.cntEnable && cycPrev && !cycNow) begin
      xferCount <= xferCount + 1'b1;
    end
  end

  assign ev.trigEdge    = trigNow & ~trigPrev;
  assign ev.cycLead     = cycNow & ~cycPrev;
  assign ev.cycTrail    = cycPrev & ~cycNow;
  assign ev.cycActive   = cycNow;
  assign ev.lastPending = (xferCount == LAST_IDX);

endmodule

// File: rtl/dma_burst_ctl.sv
module dma_burst_ctl
  import dma_burst_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         dmaEnable,
  input  dp_events_t   ev,
  output ctl_strobes_t ctl,
  output logic         drq,
  output logic         drqOe
);

  burst_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      drq   <= 1'b0;
      drqOe <= 1'b0;
    end else begin
      drqOe <= dmaEnable;
      if (!dmaEnable) begin
        state <= ST_IDLE;
        drq   <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (ev.trigEdge) begin
              state <= ST_BURST;
              drq   <= 1'b1;
            end
          end
          ST_BURST: begin
            // Withdraw the request as the final cycle starts
            if (ev.cycLead && ev.lastPending) begin
              state <= ST_TAIL;
              drq   <= 1'b0;
            end
          end
          ST_TAIL: begin
            if (ev.cycTrail) begin
              state <= ST_IDLE;
            end
          end
          default: begin
            state <= ST_IDLE;
            drq   <= 1'b0;
          end
        endcase
      end
    end
  end

  assign ctl.cntEnable = (state == ST_BURST);
  assign ctl.cntClear  = (state == ST_IDLE);

  // ev.cycActive is consumed at the top level
  logic unusedActive;
  assign unusedActive = ev.cycActive;

endmodule

// File: rtl/isa_dma_burst.sv
module isa_dma_burst
  import dma_burst_pkg::*;
#(
  parameter int BURST_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic dmaEnable,
  input  logic ior,
  input  logic iow,
  input  logic dack,
  input  logic aen,
  input  logic trigSel,
  output logic drq,
  output logic drqOe,
  output logic devSel
);

  ctl_strobes_t ctl;
  dp_events_t   ev;

  dma_burst_dp #(.BURST_LEN(BURST_LEN)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ior     (ior),
    .iow     (iow),
    .dack    (dack),
    .aen     (aen),
    .trigSel (trigSel),
    .ctl     (ctl),
    .ev      (ev)
  );

  dma_burst_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .dmaEnable (dmaEnable),
    .ev        (ev),
    .ctl       (ctl),
    .drq       (drq),
    .drqOe     (drqOe)
  );

  assign devSel = ev.cycActive & dmaEnable;

endmodule

// File: rtl/dma_burst_chk.sv
module dma_burst_chk #(
  parameter int BURST_LEN = 16
) (
  input logic clk,
  input logic rst,
  input logic dmaEnable,
  input logic ior,
  input logic iow,
  input logic dack,
  input logic aen,
  input logic trigSel,
  input logic drq,
  input logic drqOe,
  input logic devSel
);

  logic chkCycPrev;
  int   leadCnt;
  logic chkCyc;

  assign chkCyc = dack & aen & (ior | iow);

  always_ff @(posedge clk) begin
    if (rst) begin
      chkCycPrev <= 1'b0;
      leadCnt    <= 0;
    end else begin
      chkCycPrev <= chkCyc;
      if (!drq) leadCnt <= 0;
      else if (chkCyc && !chkCycPrev) leadCnt <= leadCnt + 1;
    end
  end

  AST_RISE_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (rst)
    $rose(drq) |-> $past(iow && trigSel && !aen && dmaEnable)) else $error("rise"); // R1

  AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (rst)
    drq |-> (leadCnt < BURST_LEN)) else $error("limit"); // R3

  AST_SEL_ONLY_ACK: assert property (@(posedge clk) disable iff (rst)
    devSel |-> (dack && aen)) else $error("sel"); // R5

  AST_OE_FOLLOWS_DISABLE: assert property (@(posedge clk) disable iff (rst)
    !dmaEnable |=> (!drqOe && !drq)) else $error("oe"); // R7

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!drq && !drqOe)) else $error("reset"); // R8

endmodule

bind isa_dma_burst dma_burst_chk #(.BURST_LEN(BURST_LEN)) u_chk (
  .clk(clk), .rst(rst), .dmaEnable(dmaEnable), .ior(ior), .iow(iow),
  .dack(dack), .aen(aen), .trigSel(trigSel), .drq(drq), .drqOe(drqOe),
  .devSel(devSel)
);

// File: tb/tb_isa_dma_burst.sv
module tb_isa_dma_burst;

  logic clk = 1'b0;
  logic rst, dmaEnable, ior, iow, dack, aen, trigSel;
  logic drq, drqOe, devSel;

  typedef struct {
    logic  eDrq;
    logic  eOe;
    logic  eSel;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int   total = 0;
  int   bad   = 0;
  bit   finished = 0;

  always #5 clk = ~clk;

  isa_dma_burst dut (
    .clk(clk), .rst(rst), .dmaEnable(dmaEnable), .ior(ior), .iow(iow),
    .dack(dack), .aen(aen), .trigSel(trigSel), .drq(drq), .drqOe(drqOe),
    .devSel(devSel)
  );

  // Driver: one call per clock, pushes the outputs expected after the next edge
  task automatic cyc(input logic r, input logic en, input logic rd, input logic wr,
                     input logic dk, input logic ae, input logic ts,
                     input logic eDrq, input logic eOe, input logic eSel,
                     input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; dmaEnable = en; ior = rd; iow = wr; dack = dk; aen = ae; trigSel = ts;
    e.eDrq = eDrq; e.eOe = eOe; e.eSel = eSel; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle(input logic en, input logic eDrq, input string tag);
    cyc(1'b0, en, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, eDrq, en, 1'b0, tag);
  endtask

  task automatic trig(input logic en, input logic eAfter, input logic eRel, input string tag);
    cyc(1'b0, en, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, eAfter, en, 1'b0, tag);
    idle(en, eRel, tag);
  endtask

  // One acknowledged DMA byte cycle: two active clocks then one quiet clock
  task automatic xfer(input logic toDev, input logic eDuring, input logic eAfter,
                      input string tag);
    cyc(1'b0, 1'b1, !toDev, toDev, 1'b1, 1'b1, 1'b0, eDuring, 1'b1, 1'b1, tag);
    cyc(1'b0, 1'b1, !toDev, toDev, 1'b1, 1'b1, 1'b0, eDuring, 1'b1, 1'b1, tag);
    idle(1'b1, eAfter, tag);
  endtask

  task automatic fullBurst(input string tag);
    for (int k = 1; k <= 16; k++) begin
      xfer(k[0], k < 16, k < 16, tag);
    end
  endtask

  // Monitor: compares each expected item shortly after the clock edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        total++;
        if (drq !== e.eDrq || drqOe !== e.eOe || devSel !== e.eSel) begin
          bad++;
          $display("FAIL %s: drq/oe/sel actual=%b%b%b expected=%b%b%b at %0t",
                   e.tag, drq, drqOe, devSel, e.eDrq, e.eOe, e.eSel, $time);
        end
      end
    end
  end

  initial begin
    rst = 1'b1; dmaEnable = 1'b1; ior = 0; iow = 0; dack = 0; aen = 0; trigSel = 0;
    // R8 reset state
    cyc(1'b1, 1'b1, 0, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0, "R8");
    cyc(1'b1, 1'b1, 0, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0, "R8");
    idle(1'b1, 1'b0, "R7");
    idle(1'b1, 1'b0, "R7");
    // R1 trigger raises the request
    trig(1'b1, 1'b1, 1'b1, "R1");
    // R2 / R6 first five transfers, mixed directions
    for (int k = 1; k <= 5; k++) xfer(k[0], 1'b1, 1'b1, "R2");
    // R4 trigger during the burst is ignored
    trig(1'b1, 1'b1, 1'b1, "R4");
    // R5 unqualified strobes do not count and do not select
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
    idle(1'b1, 1'b1, "R5");
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
    idle(1'b1, 1'b1, "R5");
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
    idle(1'b1, 1'b1, "R5");
    // transfers 6..15 keep the request, 16th drops it
    for (int k = 6; k <= 15; k++) xfer(k[0], 1'b1, 1'b1, "R4");
    xfer(1'b0, 1'b0, 1'b0, "R3");
    // a 17th acknowledged cycle has no effect
    xfer(1'b1, 1'b0, 1'b0, "R3");
    idle(1'b1, 1'b0, "R3");
    // R9 fresh burst after completion
    trig(1'b1, 1'b1, 1'b1, "R9");
    fullBurst("R9");
    // R7 disable releases the line and ignores triggers
    trig(1'b1, 1'b1, 1'b1, "R7");
    idle(1'b0, 1'b0, "R7");
    trig(1'b0, 1'b0, 1'b0, "R7");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    idle(1'b1, 1'b0, "R7");
    idle(1'b1, 1'b0, "R7");
    // R8 reset in mid-burst clears the count
    trig(1'b1, 1'b1, 1'b1, "R8");
    for (int k = 1; k <= 3; k++) xfer(1'b0, 1'b1, 1'b1, "R8");
    cyc(1'b1, 1'b1, 0, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0, "R8");
    idle(1'b1, 1'b0, "R8");
    trig(1'b1, 1'b1, 1'b1, "R8");
    fullBurst("R8");
    idle(1'b1, 1'b0, "R8");
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule